// File: doc/BRIEF.md
# I2C Bus Error Monitor

This block sits beside an I2C protocol engine and watches the two bus wires for trouble. It synchronizes SCL and SDA itself. It reports a bus error when a START or STOP appears while the engine says a byte is being shifted. It reports an acknowledge failure when, as transmitter, it sees SDA high on the SCL rising edge of the acknowledge bit. Both flags are sticky. The host clears each one with a write-zero strobe. An error interrupt combines the two flags under an enable.

The block also tells the engine how to recover, based on role and cause. A slave that hits a bus error drops the byte in flight and lets go of both lines. It treats a misplaced START as a repeated START and goes back to waiting for its address. It treats a misplaced STOP as an ordinary STOP. A master never gets these slave pulses. After a NACK, a master raises a sticky stop-required indication so that software issues a STOP. A slave simply releases the lines.

Top module: `i2c_buserr_monitor`

## Requirements
- R1: A START (synchronized SDA falling while synchronized SCL is high on both samples) seen while `in_byte` is 1 sets `bus_err`. The flag is visible three clock edges after the raw wire change.
- R2: A STOP (synchronized SDA rising while synchronized SCL is high on both samples) seen while `in_byte` is 1 sets `bus_err` with the same latency.
- R3: A START or STOP seen while `in_byte` is 0 leaves `bus_err` and every recovery output at 0.
- R4: `ack_fail` sets when synchronized SCL rises while `ack_slot` is 1, `is_tx` is 1 and synchronized SDA is 1. It does not set if any of these is 0.
- R5: `err_irq` equals `irq_en` AND (`bus_err` OR `ack_fail`), with no added delay in the default configuration.
- R6: A bus error in slave role (`is_master` 0) gives a one-cycle pulse on both `discard_byte` and `release_lines`.
- R7: In slave role, a misplaced START gives a one-cycle `slave_restart` pulse, and a misplaced STOP gives a one-cycle `slave_stop` pulse. The two are never high together.
- R8: In master role, no slave recovery pulse is produced. An acknowledge failure sets the sticky `stop_required`, which clears together with `ack_fail`.
- R9: An acknowledge failure in slave role pulses `release_lines` for one cycle and leaves `stop_required` at 0.
- R10: Each flag holds until its own clear strobe. A clear strobe in the same cycle as a new detection wins. Clearing one flag leaves the other unchanged.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_raw | input | 1 | SCL wire, unsynchronized |
| sda_raw | input | 1 | SDA wire, unsynchronized |
| in_byte | input | 1 | Engine is shifting a byte |
| ack_slot | input | 1 | Current bit is the acknowledge bit |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| is_tx | input | 1 | 1 = this side transmits the byte |
| irq_en | input | 1 | Error interrupt enable |
| be_clr | input | 1 | Write-zero strobe for bus_err |
| af_clr | input | 1 | Write-zero strobe for ack_fail and stop_required |
| bus_err | output | 1 | Sticky misplaced START/STOP flag |
| ack_fail | output | 1 | Sticky acknowledge failure flag |
| err_irq | output | 1 | Error interrupt |
| release_lines | output | 1 | Slave: release SCL and SDA (pulse) |
| discard_byte | output | 1 | Slave: drop byte in flight (pulse) |
| slave_restart | output | 1 | Slave: return to address phase (pulse) |
| slave_stop | output | 1 | Slave: handle as normal STOP (pulse) |
| stop_required | output | 1 | Master: software must issue STOP |

## Verification
A wrong value in the edge-history registers would show up as a false or missing condition. Within three cycles of a wire change it would appear as an unexpected `bus_err` or `ack_fail`, or as a recovery pulse landing one cycle early or late. A sticky register that leaks would clear a flag that should still be set. This shows at `err_irq` in the same cycle, and it persists until the next clear, so samples taken several cycles apart expose it. A mistake in role decoding puts a slave pulse on a master sweep, or sets `stop_required` in slave role, at the exact cycle of detection.

// File: rtl/i2c_bem_pkg.sv
package i2c_bem_pkg;
   typedef struct packed {
      logic start;
      logic stop;
      logic scl_rise;
      logic sda;
   } bus_evt_t;
endpackage

// File: rtl/i2c_bem_sync.sv
module i2c_bem_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_bem_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("i2c_bem_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= '1;
         else if (i == 0) chain[i] <= d;
         else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
   end

   assign q = chain[LAST];
endmodule

// File: rtl/i2c_bem_cond.sv
module i2c_bem_cond
   import i2c_bem_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     sda_s,
   output bus_evt_t evt
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   always_comb begin
      evt.start    = scl_s & scl_p &  sda_p & ~sda_s;
      evt.stop     = scl_s & scl_p & ~sda_p &  sda_s;
      evt.scl_rise = scl_s & ~scl_p;
      evt.sda      = sda_s;
   end
endmodule

// File: rtl/i2c_bem_flags.sv
module i2c_bem_flags
   import i2c_bem_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  bus_evt_t evt,
   input  logic     in_byte,
   input  logic     ack_slot,
   input  logic     is_master,
   input  logic     is_tx,
   input  logic     be_clr,
   input  logic     af_clr,
   output logic     bus_err,
   output logic     ack_fail,
   output logic     stop_required,
   output logic     release_lines,
   output logic     discard_byte,
   output logic     slave_restart,
   output logic     slave_stop
);
   logic bad_start, bad_stop, berr_hit, nack_hit, slave;

   assign slave     = ~is_master;
   assign bad_start = evt.start & in_byte;
   assign bad_stop  = evt.stop  & in_byte;
   assign berr_hit  = bad_start | bad_stop;
   assign nack_hit  = evt.scl_rise & evt.sda & ack_slot & is_tx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_err       <= 1'b0;
         ack_fail      <= 1'b0;
         stop_required <= 1'b0;
         release_lines <= 1'b0;
         discard_byte  <= 1'b0;
         slave_restart <= 1'b0;
         slave_stop    <= 1'b0;
      end else begin
         bus_err       <= be_clr ? 1'b0 : (bus_err | berr_hit);
         ack_fail      <= af_clr ? 1'b0 : (ack_fail | nack_hit);
         stop_required <= af_clr ? 1'b0 : (stop_required | (nack_hit & is_master));
         release_lines <= slave & (berr_hit | nack_hit);
         discard_byte  <= slave & berr_hit;
         slave_restart <= slave & bad_start;
         slave_stop    <= slave & bad_stop;
      end
   end

   // R10
   sticky_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err && !be_clr |=> bus_err);
   // R10
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      be_clr |=> !bus_err);
   // R7
   slave_pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({slave_restart, slave_stop}));
   // R6
   discard_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      discard_byte |-> release_lines);
   // R8
   stopreq_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_required |-> ack_fail);
   // R8
   master_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_master |=> !slave_restart && !slave_stop && !discard_byte);
endmodule

// File: rtl/i2c_buserr_monitor.sv
module i2c_buserr_monitor
   import i2c_bem_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   input  logic in_byte,
   input  logic ack_slot,
   input  logic is_master,
   input  logic is_tx,
   input  logic irq_en,
   input  logic be_clr,
   input  logic af_clr,
   output logic bus_err,
   output logic ack_fail,
   output logic err_irq,
   output logic release_lines,
   output logic discard_byte,
   output logic slave_restart,
   output logic slave_stop,
   output logic stop_required
);
   localparam int WIRES = 2;

   logic [WIRES-1:0] wires_s;
   bus_evt_t         evt;
   logic             irq_raw;

   i2c_bem_sync #(.STAGES(SYNC_STAGES), .WIDTH(WIRES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_raw, sda_raw}), .q(wires_s)
   );

   i2c_bem_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(wires_s[1]), .sda_s(wires_s[0]), .evt(evt)
   );

   i2c_bem_flags u_flags (
      .clk(clk), .rst_n(rst_n), .evt(evt), .in_byte(in_byte),
      .ack_slot(ack_slot), .is_master(is_master), .is_tx(is_tx),
      .be_clr(be_clr), .af_clr(af_clr), .bus_err(bus_err),
      .ack_fail(ack_fail), .stop_required(stop_required),
      .release_lines(release_lines), .discard_byte(discard_byte),
      .slave_restart(slave_restart), .slave_stop(slave_stop)
   );

   assign irq_raw = irq_en & (bus_err | ack_fail);

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) err_irq <= 1'b0;
         else err_irq <= irq_raw;
      end
   end else begin : g_irq_comb
      assign err_irq = irq_raw;
      // R5
      irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !irq_en |-> !err_irq);
      // R5
      irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
         err_irq |-> (bus_err || ack_fail));
   end
endmodule

// File: tb/sim_i2c_buserr_monitor.sv
module sim_i2c_buserr_monitor;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_raw = 1'b1, sda_raw = 1'b1;
   logic in_byte = 0, ack_slot = 0, is_master = 0, is_tx = 0, irq_en = 0;
   logic be_clr = 0, af_clr = 0;
   logic bus_err, ack_fail, err_irq, release_lines, discard_byte;
   logic slave_restart, slave_stop, stop_required;
   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   i2c_buserr_monitor u0 (
      .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .sda_raw(sda_raw),
      .in_byte(in_byte), .ack_slot(ack_slot), .is_master(is_master),
      .is_tx(is_tx), .irq_en(irq_en), .be_clr(be_clr), .af_clr(af_clr),
      .bus_err(bus_err), .ack_fail(ack_fail), .err_irq(err_irq),
      .release_lines(release_lines), .discard_byte(discard_byte),
      .slave_restart(slave_restart), .slave_stop(slave_stop),
      .stop_required(stop_required)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   // called at a negedge; drives wires, returns at the negedge after the third posedge
   task automatic bus_set(input logic s, input logic d);
      scl_raw = s;
      sda_raw = d;
      repeat (3) @(negedge clk);
   endtask

   task automatic clr_all();
      be_clr = 1; af_clr = 1;
      @(negedge clk);
      be_clr = 0; af_clr = 0;
   endtask

   task automatic go_idle();
      in_byte = 0; ack_slot = 0;
      bus_set(0, sda_raw);
      bus_set(0, 1);
      bus_set(1, 1);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11", "bus_err", bus_err, 0);
      chk("R11", "ack_fail", ack_fail, 0);
      chk("R11", "err_irq", err_irq, 0);
      chk("R11", "release", release_lines, 0);
      chk("R11", "stop_req", stop_required, 0);
      rst_n = 1;
      repeat (4) @(negedge clk);

      // R1 R2 R3 R6 R7 R8: misplaced condition sweep
      for (int c = 0; c < 8; c++) begin
         automatic logic m   = c[0];
         automatic logic inb = c[1];
         automatic logic stp = c[2];
         go_idle();
         if (stp) begin
            bus_set(0, 1); bus_set(0, 0); bus_set(1, 0);
         end
         clr_all();
         is_master = m; in_byte = inb; irq_en = 1;
         bus_set(1, stp ? 1'b1 : 1'b0);
         chk(stp ? "R2" : "R1", "bus_err", bus_err, inb);
         chk("R3", "ack_fail", ack_fail, 0);
         chk("R6", "discard", discard_byte, inb & ~m);
         chk("R6", "release", release_lines, inb & ~m);
         chk("R7", "restart", slave_restart, inb & ~m & ~stp);
         chk("R7", "slave_stop", slave_stop, inb & ~m & stp);
         chk("R5", "irq", err_irq, inb);
         @(negedge clk);
         chk("R6", "pulse one cycle", release_lines, 0);
         repeat (4) @(negedge clk);
         chk("R10", "bus_err sticky", bus_err, inb);
      end

      // R4 R5 R8 R9: acknowledge slot sweep
      for (int c = 0; c < 32; c++) begin
         automatic logic m   = c[0];
         automatic logic tx  = c[1];
         automatic logic d   = c[2];
         automatic logic as  = c[3];
         automatic logic en  = c[4];
         automatic logic exp_af = as & tx & d;
         go_idle();
         bus_set(0, d);
         clr_all();
         is_master = m; is_tx = tx; ack_slot = as; in_byte = 0; irq_en = en;
         bus_set(1, d);
         chk("R4", "ack_fail", ack_fail, exp_af);
         chk("R8", "stop_required", stop_required, exp_af & m);
         chk("R9", "release", release_lines, exp_af & ~m);
         chk("R5", "irq", err_irq, en & exp_af);
         chk("R3", "bus_err", bus_err, 0);
      end

      // R10: independent clears
      go_idle();
      is_master = 1; is_tx = 1; ack_slot = 1; irq_en = 1;
      bus_set(0, 1); bus_set(1, 1);
      ack_slot = 0; in_byte = 1;
      bus_set(1, 0);
      chk("R10", "both set be", bus_err, 1);
      chk("R10", "both set af", ack_fail, 1);
      be_clr = 1; @(negedge clk); be_clr = 0;
      chk("R10", "be cleared", bus_err, 0);
      chk("R10", "af kept", ack_fail, 1);
      chk("R8", "stop_req kept", stop_required, 1);
      af_clr = 1; @(negedge clk); af_clr = 0;
      chk("R10", "af cleared", ack_fail, 0);
      chk("R8", "stop_req cleared", stop_required, 0);
      chk("R5", "irq off", err_irq, 0);

      // R10: clear in the detection cycle wins
      go_idle();
      is_master = 0; in_byte = 1;
      sda_raw = 0;
      @(negedge clk); @(negedge clk);
      be_clr = 1;
      @(negedge clk);
      be_clr = 0;
      chk("R10", "clear wins", bus_err, 0);
      chk("R7", "restart still pulses", slave_restart, 1);
      @(negedge clk);
      chk("R10", "stays clear", bus_err, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule